// File: doc/BRIEF.md
# Zero-Minimising Bit-Inversion Codec for Flash Pages

This block sits between a flash controller's staging buffer and its flash interface. Programming a cell to 0 moves charge through the tunnel oxide and wears the cell. The block lowers the number of zeros that reach the array. The write path takes a byte stream and holds one inversion unit (`UNIT_BYTES` bytes) at a time. While the unit arrives, the block counts its zero bits. Once the unit is complete, the block decides whether to invert it, then sends it on. A unit with more zeros than `THRESH` goes out complemented. A one-bit flag, meant for the page's spare area, travels on a sideband next to the unit's final byte.

The read path takes stored bytes and the stored flag of each unit. It complements every byte of a unit whose flag is 1 and passes a unit with flag 0 unchanged, so the host sees the original data. The unit size is a parameter and must be set to suit the page layout, for example 512 or 2048 bytes. Smaller units give more chances to remove zeros but need more flag bits. `THRESH` defaults to half the unit's bit count.

The write path is a three-state machine:
- FILL accepts input bytes.
- DECIDE lasts one cycle and fixes the inversion choice.
- DRAIN emits the unit.

Its transitions are:
- UNIT_FULL: FILL to DECIDE, when the last byte of a unit is accepted.
- DECIDED: DECIDE to DRAIN, unconditionally.
- UNIT_SENT: DRAIN to FILL, when the last byte of the unit is taken.

Top module: `flash_inv_codec`

## Requirements
- R1: After reset, `wr_in_ready` is 1, `wr_out_valid` is 0 and `rd_out_valid` is 0.
- R2: No byte of a unit is offered on the write output until all `UNIT_BYTES` bytes of that unit have been accepted. `wr_in_ready` is 0 in the DECIDE cycle and throughout DRAIN, and DECIDE lasts exactly one cycle.
- R3: A unit with a zero-bit count strictly above `THRESH` is emitted with every byte bitwise complemented, and its flag is 1.
- R4: A unit with a zero-bit count at or below `THRESH` is emitted unchanged with flag 0. A count exactly equal to `THRESH` does not invert.
- R5: `wr_out_last` is 1 on exactly the `UNIT_BYTES`-th output byte of each unit. `wr_out_flag` carries the unit's flag on that byte and is 0 on all others.
- R6: Write output bytes keep their input order. While `wr_out_valid` is 1 and `wr_out_ready` is 0, the data, last and flag outputs hold steady.
- R7: On the read path, `rd_in_flag` is sampled only with the first byte of each unit. A sampled 1 complements every byte of the unit and a sampled 0 passes the unit unchanged, whatever `rd_in_flag` does on later bytes.
- R8: The read path has one register stage: `rd_in_ready` equals `!rd_out_valid || rd_out_ready`. `rd_out_last` is 1 on the `UNIT_BYTES`-th byte of each unit, and a stalled output holds its data.
- R9: No encoded unit holds more than `THRESH` zero bits. Feeding encoded units with their flags back through the read path yields the original bytes exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_in_data | input | 8 | Write byte from the staging buffer |
| wr_in_valid | input | 1 | Write byte present |
| wr_in_ready | output | 1 | Codec accepts a write byte |
| wr_out_data | output | 8 | Coded byte toward flash |
| wr_out_valid | output | 1 | Coded byte present |
| wr_out_ready | input | 1 | Flash side takes the coded byte |
| wr_out_last | output | 1 | Final byte of a unit |
| wr_out_flag | output | 1 | Unit's inversion flag, valid with the final byte |
| rd_in_data | input | 8 | Byte read from flash |
| rd_in_flag | input | 1 | Stored flag of the unit, sampled with its first byte |
| rd_in_valid | input | 1 | Read byte present |
| rd_in_ready | output | 1 | Codec accepts a read byte |
| rd_out_data | output | 8 | Restored byte |
| rd_out_valid | output | 1 | Restored byte present |
| rd_out_ready | input | 1 | Consumer takes the restored byte |
| rd_out_last | output | 1 | Final restored byte of a unit |

## Verification
The assertions check these properties on every cycle:
- Input and output never overlap on the write side.
- The write input count sits at a unit boundary whenever output is offered.
- Stalled outputs hold steady on both paths.
- The flag appears only on a final byte.
- The zero count of every emitted unit stays at or below the threshold.

Only the bench scenarios can show the following:
- The choice between inverting and passing is correct at the exact threshold, one above it and one below it.
- The byte order is preserved.
- The read flag is ignored after a unit's first byte.
- Encoded data comes back bit-exact through the read path.

// File: rtl/inv_pkg.sv
package inv_pkg;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_DRAIN  = 2'd2
    } wr_state_e;

    function automatic logic [3:0] zeros_in_byte(input logic [7:0] b);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, ~b[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/inv_zero_tally.sv
module inv_zero_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [7:0]       byte_in,
    output logic [CNT_W-1:0] count
);
    import inv_pkg::*;

    logic [CNT_W-1:0] add_val;

    always_comb begin
        add_val = CNT_W'(zeros_in_byte(byte_in));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (add_en) begin
            count <= count + add_val;
        end
    end

endmodule

// File: rtl/inv_unit_store.sv
module inv_unit_store #(
    parameter int DEPTH = 512,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/inv_read_restore.sv
module inv_read_restore #(
    parameter int UNIT_BYTES = 512,
    parameter int IDX_W      = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_flag,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(UNIT_BYTES - 1);

    logic [IDX_W-1:0] idx;
    logic             flag_q;
    logic             flag_use;
    logic             in_fire;
    logic             out_fire;

    always_comb begin
        in_ready = !out_valid || out_ready;
        in_fire  = in_valid && in_ready;
        out_fire = out_valid && out_ready;
        flag_use = (idx == '0) ? in_flag : flag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            flag_q    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            out_last  <= 1'b0;
        end else begin
            if (in_fire) begin
                out_data  <= in_data ^ {8{flag_use}};
                out_last  <= (idx == LAST_IDX);
                out_valid <= 1'b1;
                flag_q    <= flag_use;
                idx       <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            end else if (out_fire) begin
                out_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flash_inv_codec.sv
module flash_inv_codec #(
    parameter int UNIT_BYTES = 512,
    parameter int THRESH     = UNIT_BYTES * 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wr_in_data,
    input  logic       wr_in_valid,
    output logic       wr_in_ready,
    output logic [7:0] wr_out_data,
    output logic       wr_out_valid,
    input  logic       wr_out_ready,
    output logic       wr_out_last,
    output logic       wr_out_flag,
    input  logic [7:0] rd_in_data,
    input  logic       rd_in_flag,
    input  logic       rd_in_valid,
    output logic       rd_in_ready,
    output logic [7:0] rd_out_data,
    output logic       rd_out_valid,
    input  logic       rd_out_ready,
    output logic       rd_out_last
);
    import inv_pkg::*;

    localparam int UNIT_BITS = UNIT_BYTES * 8;
    localparam int IDX_W     = (UNIT_BYTES > 1) ? $clog2(UNIT_BYTES) : 1;
    localparam int CNT_W     = $clog2(UNIT_BITS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(UNIT_BYTES - 1);
    localparam logic [CNT_W-1:0] THRESH_C = CNT_W'(THRESH);

    wr_state_e        state;
    wr_state_e        state_n;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] zero_cnt;
    logic             invert_q;
    logic [7:0]       store_q;
    logic             in_fire;
    logic             out_fire;
    logic             at_last;
    logic             tally_clear;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FILL;
        end else begin
            state <= state_n;
        end
    end

    // Transitions: UNIT_FULL, DECIDED, UNIT_SENT
    always_comb begin
        state_n = state;
        unique case (state)
            ST_FILL:   if (in_fire && at_last)  state_n = ST_DECIDE;
            ST_DECIDE:                          state_n = ST_DRAIN;
            ST_DRAIN:  if (out_fire && at_last) state_n = ST_FILL;
            default:                            state_n = ST_FILL;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        wr_in_ready  = 1'b0;
        wr_out_valid = 1'b0;
        tally_clear  = 1'b0;
        unique case (state)
            ST_FILL:   wr_in_ready  = 1'b1;
            ST_DECIDE: tally_clear  = 1'b1;
            ST_DRAIN:  wr_out_valid = 1'b1;
            default:   wr_in_ready  = 1'b0;
        endcase
        at_last     = (idx == LAST_IDX);
        in_fire     = wr_in_valid && wr_in_ready;
        out_fire    = wr_out_valid && wr_out_ready;
        wr_out_data = store_q ^ {8{invert_q}};
        wr_out_last = wr_out_valid && at_last;
        wr_out_flag = wr_out_last && invert_q;
    end

    // Byte index shared by filling and draining
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (in_fire || out_fire) begin
            idx <= at_last ? '0 : idx + 1'b1;
        end
    end

    // Inversion choice fixed in DECIDE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            invert_q <= 1'b0;
        end else if (state == ST_DECIDE) begin
            invert_q <= (zero_cnt > THRESH_C);
        end
    end

    inv_zero_tally #(.CNT_W(CNT_W)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tally_clear),
        .add_en  (in_fire),
        .byte_in (wr_in_data),
        .count   (zero_cnt)
    );

    inv_unit_store #(.DEPTH(UNIT_BYTES), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (in_fire),
        .waddr (idx),
        .wdata (wr_in_data),
        .raddr (idx),
        .rdata (store_q)
    );

    inv_read_restore #(.UNIT_BYTES(UNIT_BYTES), .IDX_W(IDX_W)) u_restore (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (rd_in_data),
        .in_flag   (rd_in_flag),
        .in_valid  (rd_in_valid),
        .in_ready  (rd_in_ready),
        .out_data  (rd_out_data),
        .out_valid (rd_out_valid),
        .out_ready (rd_out_ready),
        .out_last  (rd_out_last)
    );

endmodule

// File: rtl/inv_codec_chk.sv
module inv_codec_chk #(
    parameter int UNIT_BYTES = 512,
    parameter int THRESH     = UNIT_BYTES * 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_in_valid,
    input logic       wr_in_ready,
    input logic [7:0] wr_out_data,
    input logic       wr_out_valid,
    input logic       wr_out_ready,
    input logic       wr_out_last,
    input logic       wr_out_flag,
    input logic [7:0] rd_out_data,
    input logic       rd_out_valid,
    input logic       rd_out_ready,
    input logic       rd_out_last
);
    import inv_pkg::*;

    localparam int CW = $clog2(UNIT_BYTES * 8 + 1) + 1;

    int          in_cnt;
    logic [CW-1:0] out_zeros;
    logic [CW-1:0] beat_zeros;

    assign beat_zeros = CW'(zeros_in_byte(wr_out_data));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt    <= 0;
            out_zeros <= '0;
        end else begin
            if (wr_in_valid && wr_in_ready) begin
                in_cnt <= (in_cnt == UNIT_BYTES - 1) ? 0 : in_cnt + 1;
            end
            if (wr_out_valid && wr_out_ready) begin
                out_zeros <= wr_out_last ? '0 : out_zeros + beat_zeros;
            end
        end
    end

    // R2
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out_valid |-> !wr_in_ready);

    // R2
    a_r2_whole_unit_first: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out_valid |-> (in_cnt == 0));

    // R5
    a_r5_flag_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out_valid && !wr_out_last) |-> !wr_out_flag);

    // R6
    a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out_valid && !wr_out_ready) |=> (wr_out_valid && $stable(wr_out_data)
            && $stable(wr_out_last) && $stable(wr_out_flag)));

    // R8
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && !rd_out_ready) |=> (rd_out_valid && $stable(rd_out_data)
            && $stable(rd_out_last)));

    // R9
    a_r9_zero_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out_valid && wr_out_ready && wr_out_last)
            |-> ((out_zeros + beat_zeros) <= CW'(THRESH)));

endmodule

bind flash_inv_codec inv_codec_chk #(.UNIT_BYTES(UNIT_BYTES), .THRESH(THRESH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_in_valid  (wr_in_valid),
    .wr_in_ready  (wr_in_ready),
    .wr_out_data  (wr_out_data),
    .wr_out_valid (wr_out_valid),
    .wr_out_ready (wr_out_ready),
    .wr_out_last  (wr_out_last),
    .wr_out_flag  (wr_out_flag),
    .rd_out_data  (rd_out_data),
    .rd_out_valid (rd_out_valid),
    .rd_out_ready (rd_out_ready),
    .rd_out_last  (rd_out_last)
);

// File: tb/tb_flash_inv_codec.sv
module tb_flash_inv_codec;

    localparam int UB = 8;
    localparam int TH = UB * 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_in_data = 8'h00;
    logic       wr_in_valid = 1'b0;
    logic       wr_in_ready;
    logic [7:0] wr_out_data;
    logic       wr_out_valid;
    logic       wr_out_ready = 1'b1;
    logic       wr_out_last;
    logic       wr_out_flag;
    logic [7:0] rd_in_data = 8'h00;
    logic       rd_in_flag = 1'b0;
    logic       rd_in_valid = 1'b0;
    logic       rd_in_ready;
    logic [7:0] rd_out_data;
    logic       rd_out_valid;
    logic       rd_out_ready = 1'b1;
    logic       rd_out_last;

    flash_inv_codec #(.UNIT_BYTES(UB)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_in_data(wr_in_data), .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready),
        .wr_out_data(wr_out_data), .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready),
        .wr_out_last(wr_out_last), .wr_out_flag(wr_out_flag),
        .rd_in_data(rd_in_data), .rd_in_flag(rd_in_flag), .rd_in_valid(rd_in_valid),
        .rd_in_ready(rd_in_ready), .rd_out_data(rd_out_data), .rd_out_valid(rd_out_valid),
        .rd_out_ready(rd_out_ready), .rd_out_last(rd_out_last)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] exp_w[$];
    logic       exp_f[$];
    logic [7:0] enc[$];
    logic       encf[$];
    logic [7:0] exp_r[$];
    logic [7:0] ubuf[UB];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int zc(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) if (!b[i]) n++;
        return n;
    endfunction

    function automatic logic [7:0] next_rand();
        for (int i = 0; i < 8; i++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0];
    endfunction

    // Output stall patterns
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        wr_out_ready = (cyc % 4) != 1;
        rd_out_ready = (cyc % 3) != 2;
    end

    // Cycle-by-cycle reference model of the write path
    int mph = 0;
    int mn  = 0;
    int oz  = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mph = 0; mn = 0; oz = 0;
        end else begin
            case (mph)
                0: begin
                    chk(wr_in_ready == 1'b1 && wr_out_valid == 1'b0, "R2 fill phase",
                        {wr_in_ready, wr_out_valid}, 2'b10);
                    if (wr_in_valid) begin
                        mn++;
                        if (mn == UB) begin mph = 1; mn = 0; end
                    end
                end
                1: begin
                    chk(wr_in_ready == 1'b0 && wr_out_valid == 1'b0, "R2 decide cycle",
                        {wr_in_ready, wr_out_valid}, 2'b00);
                    mph = 2;
                end
                default: begin
                    chk(wr_in_ready == 1'b0 && wr_out_valid == 1'b1, "R2 drain phase",
                        {wr_in_ready, wr_out_valid}, 2'b01);
                    if (wr_out_ready && exp_w.size() > 0) begin
                        chk(wr_out_data == exp_w[0], "R3/R4/R6 write data", wr_out_data, exp_w[0]);
                        chk(wr_out_last == (mn == UB - 1), "R5 last", wr_out_last, mn == UB - 1);
                        chk(wr_out_flag == ((mn == UB - 1) ? exp_f[0] : 1'b0), "R5 flag",
                            wr_out_flag, (mn == UB - 1) ? exp_f[0] : 1'b0);
                        oz += zc(wr_out_data);
                        enc.push_back(wr_out_data);
                        void'(exp_w.pop_front());
                        mn++;
                        if (mn == UB) begin
                            chk(oz <= TH, "R9 zero bound", oz, TH);
                            encf.push_back(wr_out_flag);
                            void'(exp_f.pop_front());
                            oz = 0; mn = 0; mph = 0;
                        end
                    end
                end
            endcase
        end
    end

    // Cycle-by-cycle reference model of the read path
    bit rv = 0;
    int rn = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            rv = 0; rn = 0;
        end else begin
            chk(rd_in_ready == (!rv || rd_out_ready), "R8 read ready", rd_in_ready, !rv || rd_out_ready);
            chk(rd_out_valid == rv, "R8 read valid", rd_out_valid, rv);
            if (rv && rd_out_ready && exp_r.size() > 0) begin
                chk(rd_out_data == exp_r[0], "R7/R9 read data", rd_out_data, exp_r[0]);
                chk(rd_out_last == (rn == UB - 1), "R8 read last", rd_out_last, rn == UB - 1);
                void'(exp_r.pop_front());
                rn = (rn == UB - 1) ? 0 : rn + 1;
                rv = 0;
            end
            if (rd_in_valid && (!rv || rd_out_ready)) rv = 1;
        end
    end

    task automatic put_w(input logic [7:0] b);
        wr_in_valid = 1'b1;
        wr_in_data  = b;
        @(negedge clk);
        while (!wr_in_ready) @(negedge clk);
        @(posedge clk); #2;
        wr_in_valid = 1'b0;
    endtask

    task automatic send_w(input bit gaps);
        int z = 0;
        bit inv;
        for (int i = 0; i < UB; i++) z += zc(ubuf[i]);
        inv = (z > TH);
        for (int i = 0; i < UB; i++) exp_w.push_back(ubuf[i] ^ {8{inv}});
        exp_f.push_back(inv);
        for (int i = 0; i < UB; i++) begin
            put_w(ubuf[i]);
            if (gaps && i == 2) begin @(posedge clk); #2; end
        end
    endtask

    task automatic put_r(input logic [7:0] b, input logic f);
        rd_in_valid = 1'b1;
        rd_in_data  = b;
        rd_in_flag  = f;
        @(negedge clk);
        while (!rd_in_ready) @(negedge clk);
        @(posedge clk); #2;
        rd_in_valid = 1'b0;
    endtask

    task automatic fill(input logic [7:0] first, input logic [7:0] rest);
        ubuf[0] = first;
        for (int i = 1; i < UB; i++) ubuf[i] = rest;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wr_in_ready == 1'b1, "R1 wr_in_ready", wr_in_ready, 1);
        chk(wr_out_valid == 1'b0, "R1 wr_out_valid", wr_out_valid, 0);
        chk(rd_out_valid == 1'b0, "R1 rd_out_valid", rd_out_valid, 0);
        @(posedge clk); #2;

        fill(8'h00, 8'h00); send_w(0);   // R3 all zeros
        fill(8'hFF, 8'hFF); send_w(1);   // R4 all ones
        fill(8'h0F, 8'h0F); send_w(0);   // R4 exactly TH zeros: pass
        fill(8'h0E, 8'h0F); send_w(1);   // R3 TH+1 zeros: invert
        fill(8'h1F, 8'h0F); send_w(0);   // R4 TH-1 zeros
        for (int u = 0; u < 6; u++) begin
            for (int i = 0; i < UB; i++) ubuf[i] = (u % 2) ? (next_rand() & 8'hB5) : next_rand();
            send_w(u % 2);
        end
        while (exp_w.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk); #2;
        chk(encf.size() == 11, "R5 unit flags seen", encf.size(), 11);
        chk(encf[0] == 1'b1 && encf[2] == 1'b0 && encf[3] == 1'b1, "R3/R4 threshold flags",
            {encf[0], encf[2], encf[3]}, 3'b101);

        // R9 round trip: decode expected to equal original data
        for (int u = 0; u < encf.size(); u++) begin
            for (int i = 0; i < UB; i++) exp_r.push_back(enc[u*UB+i] ^ {8{encf[u]}});
            for (int i = 0; i < UB; i++) put_r(enc[u*UB+i], encf[u]);
        end
        // R7: flag sampled on first byte only
        for (int i = 0; i < UB; i++) exp_r.push_back(8'h30 + 8'(i) ^ 8'hFF);
        for (int i = 0; i < UB; i++) put_r(8'h30 + 8'(i), (i == 0));
        for (int i = 0; i < UB; i++) exp_r.push_back(8'h50 + 8'(i));
        for (int i = 0; i < UB; i++) put_r(8'h50 + 8'(i), (i != 0));
        while (exp_r.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
        chk(rd_out_valid == 1'b0, "R8 read drained", rd_out_valid, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_w.size() + exp_r.size());
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule